// File: doc/BRIEF.md
# Polled Parallel-Disk Sector Reader

This block is the host side of a parallel disk register bus. A client hands it one request: the channel, the drive, a 28-bit logical block address, a sector count and a flag that picks plain reading or device detection. The block programs the device's task-file registers one byte per cycle. It then issues the command and polls the status register. After that it moves the returned 16-bit words out on a valid/ready stream. It ends every request with a one-cycle completion pulse and a result code.

In read mode the block polls status again before each sector and then reads 256 words from the data register. A status error makes it fetch the error byte and stop. A poll that makes no progress for a programmable number of reads ends the request with a timeout. In detect mode it sends the identify command. It reports "no device" when the status shows an error or no data request once busy clears. Otherwise it streams the 256 identify words.

States: IDLE (waits for a request), WR_DEV, WR_CNT, WR_LO, WR_MID, WR_HI and WR_CMD (one task-file write each), POLL (status read every cycle), RD_ERR (error byte fetch), XFER (data word reads), DRAIN (waits for the last word to leave) and FINISH (completion pulse). IDLE goes to WR_DEV, or straight to FINISH for a zero count. WR_DEV goes to WR_CMD in detect mode and to WR_CNT otherwise. WR_CNT, WR_LO, WR_MID and WR_HI follow one another, and WR_HI goes to WR_CMD. WR_CMD goes to POLL. POLL goes to XFER, RD_ERR or FINISH, or stays. XFER goes back to POLL after a sector that is not the last one and to DRAIN after the final word. DRAIN goes to FINISH, and FINISH returns to IDLE.

Top module: `pio_sector_reader`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a cycle with `req_valid` and `req_ready` both high. `done` lasts exactly one cycle, and `req_ready` is high on the next cycle. `done_code` encodes the result: 0 = ok, 1 = no device, 2 = device error, 3 = timeout, 4 = bad count.
- R2: A read request writes the task file in the offset order 6, 2, 3, 4, 5, 7. A detect request writes offsets 6 and 7 only. The byte at offset 6 is {1, 1, 1, drive, lba[27:24]} for a read and {1, 0, 1, drive, 0000} for a detect, so a detect gives 0xA0 for drive 0 and 0xB0 for drive 1.
- R3: Offset 2 receives the sector count. Offset 3 receives lba[7:0], offset 4 receives lba[15:8] and offset 5 receives lba[23:16]. Offset 7 receives 0x20 for a read and 0xEC for a detect. The byte sits in `ata_wdata[7:0]`, and bits 15:8 are 0.
- R4: Every bus access puts out `io_port` = base + offset, with base 0x1F0 when `req_chan`=0 and 0x170 when `req_chan`=1. `ata_cs_cmd` is high during every access.
- R5: In POLL the block reads offset 7 once per cycle. It stays there while status bit 7 (busy) is set, and in read mode it also stays while bit 3 (data request) is clear. It moves no data before both conditions are met. It polls again before every sector, not only the first.
- R6: Each sector yields exactly 256 reads of offset 0, so a read request yields 256 × count words on the stream in bus order. `out_last` is high with the final word only.
- R7: In detect mode, once busy is clear, status bit 0 (error) set or bit 3 clear ends the request with code 1 and no words. Otherwise it streams 256 words and ends with code 0.
- R8: In read mode, error bit 0 set with busy clear makes the block read offset 1 once. It shows that byte on `err_reg` and ends with code 2.
- R9: When `limit+1` consecutive status reads in one POLL visit do not allow progress, the request ends with code 3. Here limit is `cfg_poll_limit`.
- R10: A read request with count 0 makes no bus access, and `done` with code 4 comes on the cycle after acceptance.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and no data-register read is strobed.
- R12: `ata_rd` and `ata_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_poll_limit | input | TO_W | Status-poll budget per POLL visit |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and accepting |
| req_detect | input | 1 | 1 = detect (identify), 0 = read |
| req_chan | input | 1 | 0 = first channel, 1 = second channel |
| req_drive | input | 1 | Drive select |
| req_lba | input | 28 | Starting logical block address |
| req_count | input | CNT_W | Sector count (read mode) |
| io_port | output | 10 | Full I/O address of the access |
| ata_reg | output | 3 | Task-file register offset |
| ata_cs_cmd | output | 1 | Command-block select |
| ata_rd | output | 1 | Read strobe |
| ata_wr | output | 1 | Write strobe |
| ata_wdata | output | 16 | Write data |
| ata_rdata | input | 16 | Read data, valid in the strobe cycle |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | 16 | Stream word |
| out_last | output | 1 | Final word of the request |
| done | output | 1 | Completion pulse |
| done_code | output | 3 | Result code |
| err_reg | output | 8 | Captured error byte |

## Verification
The first write comes one cycle after acceptance and the rest follow one per cycle. Status reads start in the cycle after the command write. A data word reaches `out_data` one cycle after its read strobe, and `done` comes one cycle after the final word is taken. For a zero count `done` comes one cycle after acceptance. The bench changes inputs on the falling edge and then waits 1 ns before it samples. It records a stream word only when `out_valid` and its own `out_ready` are both high before the next rising edge. It checks the zero-count timing by the exact cycle and counts the status reads to check the timeout.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_WR_DEV, S_WR_CNT, S_WR_LO, S_WR_MID, S_WR_HI,
        S_WR_CMD, S_POLL, S_RD_ERR, S_XFER, S_DRAIN, S_FINISH
    } state_t;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_NODEV   = 3'd1,
        RES_DEVERR  = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_BADCNT  = 3'd4
    } res_t;

    localparam logic [7:0] CMD_READ  = 8'h20;
    localparam logic [7:0] CMD_IDENT = 8'hEC;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_ERR  = 3'd1;
    localparam logic [2:0] OFS_CNT  = 3'd2;
    localparam logic [2:0] OFS_LO   = 3'd3;
    localparam logic [2:0] OFS_MID  = 3'd4;
    localparam logic [2:0] OFS_HI   = 3'd5;
    localparam logic [2:0] OFS_DEV  = 3'd6;
    localparam logic [2:0] OFS_CMD  = 3'd7;

    localparam int ST_BUSY = 7;
    localparam int ST_DREQ = 3;
    localparam int ST_ERR  = 0;

endpackage

// File: rtl/pio_port_map.sv
module pio_port_map #(
    parameter logic [9:0] PRI_BASE = 10'h1F0,
    parameter logic [9:0] SEC_BASE = 10'h170
) (
    input  logic       chan,
    input  logic [2:0] ofs,
    input  logic       rd,
    input  logic       wr,
    output logic [9:0] io_port,
    output logic       cs_cmd
);
    always_comb begin
        io_port = (chan ? SEC_BASE : PRI_BASE) + {7'd0, ofs};
        cs_cmd  = rd | wr;
    end
endmodule

// File: rtl/pio_poll_timer.sv
module pio_poll_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            en,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (clear)                      cnt <= '0;
        else if (en && (cnt != '1))          cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/pio_sector_reader.sv
module pio_sector_reader
    import pio_rd_pkg::*;
#(
    parameter int         CNT_W    = 8,
    parameter int         WORDS    = 256,
    parameter int         TO_W     = 16,
    parameter logic [9:0] PRI_BASE = 10'h1F0,
    parameter logic [9:0] SEC_BASE = 10'h170
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TO_W-1:0]  cfg_poll_limit,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_detect,
    input  logic             req_chan,
    input  logic             req_drive,
    input  logic [27:0]      req_lba,
    input  logic [CNT_W-1:0] req_count,
    output logic [9:0]       io_port,
    output logic [2:0]       ata_reg,
    output logic             ata_cs_cmd,
    output logic             ata_rd,
    output logic             ata_wr,
    output logic [15:0]      ata_wdata,
    input  logic [15:0]      ata_rdata,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [15:0]      out_data,
    output logic             out_last,
    output logic             done,
    output logic [2:0]       done_code,
    output logic [7:0]       err_reg
);
    localparam int WCNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    state_t st, st_n;
    res_t   code_r, code_n;

    logic              det_r, chan_r, drive_r;
    logic [27:0]       lba_r;
    logic [CNT_W-1:0]  cnt_r, sec_r;
    logic [WCNT_W-1:0] wcnt_r;
    logic              fire, err_cap, sec_step, tmr_exp;
    logic [7:0]        wbyte;
    logic              word_last, sec_last, slot_free;

    assign word_last = (wcnt_r == WCNT_W'(WORDS - 1));
    assign sec_last  = (sec_r == cnt_r - CNT_W'(1));
    assign slot_free = !out_valid || out_ready;

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            code_r    <= RES_OK;
            det_r     <= 1'b0;
            chan_r    <= 1'b0;
            drive_r   <= 1'b0;
            lba_r     <= '0;
            cnt_r     <= '0;
            sec_r     <= '0;
            wcnt_r    <= '0;
            err_reg   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            st     <= st_n;
            code_r <= code_n;
            if (st == S_IDLE && req_valid) begin
                det_r   <= req_detect;
                chan_r  <= req_chan;
                drive_r <= req_drive;
                lba_r   <= req_lba;
                cnt_r   <= req_detect ? CNT_W'(1) : req_count;
                sec_r   <= '0;
                wcnt_r  <= '0;
                err_reg <= '0;
            end
            if (sec_step) sec_r <= sec_r + 1'b1;
            if (err_cap)  err_reg <= ata_rdata[7:0];
            if (fire) begin
                wcnt_r    <= word_last ? '0 : wcnt_r + 1'b1;
                out_valid <= 1'b1;
                out_data  <= ata_rdata;
                out_last  <= word_last && sec_last;
            end else if (out_ready) begin
                out_valid <= 1'b0;
                out_last  <= 1'b0;
            end
        end
    end

    // Next state and bus outputs
    always_comb begin
        st_n     = st;
        code_n   = code_r;
        ata_rd   = 1'b0;
        ata_wr   = 1'b0;
        ata_reg  = OFS_DATA;
        wbyte    = 8'h00;
        fire     = 1'b0;
        err_cap  = 1'b0;
        sec_step = 1'b0;
        unique case (st)
            S_IDLE: if (req_valid) begin
                if (!req_detect && req_count == '0) begin
                    st_n   = S_FINISH;
                    code_n = RES_BADCNT;
                end else begin
                    st_n   = S_WR_DEV;
                    code_n = RES_OK;
                end
            end
            S_WR_DEV: begin
                ata_wr  = 1'b1;
                ata_reg = OFS_DEV;
                wbyte   = det_r ? {3'b101, drive_r, 4'h0}
                                : {3'b111, drive_r, lba_r[27:24]};
                st_n    = det_r ? S_WR_CMD : S_WR_CNT;
            end
            S_WR_CNT: begin
                ata_wr = 1'b1; ata_reg = OFS_CNT; wbyte = 8'(cnt_r); st_n = S_WR_LO;
            end
            S_WR_LO: begin
                ata_wr = 1'b1; ata_reg = OFS_LO; wbyte = lba_r[7:0]; st_n = S_WR_MID;
            end
            S_WR_MID: begin
                ata_wr = 1'b1; ata_reg = OFS_MID; wbyte = lba_r[15:8]; st_n = S_WR_HI;
            end
            S_WR_HI: begin
                ata_wr = 1'b1; ata_reg = OFS_HI; wbyte = lba_r[23:16]; st_n = S_WR_CMD;
            end
            S_WR_CMD: begin
                ata_wr  = 1'b1;
                ata_reg = OFS_CMD;
                wbyte   = det_r ? CMD_IDENT : CMD_READ;
                st_n    = S_POLL;
            end
            S_POLL: begin
                ata_rd  = 1'b1;
                ata_reg = OFS_CMD;
                if (ata_rdata[ST_BUSY]) begin
                    if (tmr_exp) begin st_n = S_FINISH; code_n = RES_TIMEOUT; end
                end else if (ata_rdata[ST_ERR]) begin
                    if (det_r) begin st_n = S_FINISH; code_n = RES_NODEV; end
                    else st_n = S_RD_ERR;
                end else if (!ata_rdata[ST_DREQ]) begin
                    if (det_r)        begin st_n = S_FINISH; code_n = RES_NODEV; end
                    else if (tmr_exp) begin st_n = S_FINISH; code_n = RES_TIMEOUT; end
                end else begin
                    st_n = S_XFER;
                end
            end
            S_RD_ERR: begin
                ata_rd  = 1'b1;
                ata_reg = OFS_ERR;
                err_cap = 1'b1;
                st_n    = S_FINISH;
                code_n  = RES_DEVERR;
            end
            S_XFER: if (slot_free) begin
                ata_rd  = 1'b1;
                ata_reg = OFS_DATA;
                fire    = 1'b1;
                if (word_last) begin
                    if (sec_last) st_n = S_DRAIN;
                    else begin st_n = S_POLL; sec_step = 1'b1; end
                end
            end
            S_DRAIN:  if (slot_free) st_n = S_FINISH;
            S_FINISH: st_n = S_IDLE;
            default:  st_n = S_IDLE;
        endcase
    end

    assign ata_wdata = {8'h00, wbyte};
    assign req_ready = (st == S_IDLE);
    assign done      = (st == S_FINISH);
    assign done_code = code_r;

    pio_port_map #(.PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE)) u_map (
        .chan    (chan_r),
        .ofs     (ata_reg),
        .rd      (ata_rd),
        .wr      (ata_wr),
        .io_port (io_port),
        .cs_cmd  (ata_cs_cmd)
    );

    pio_poll_timer #(.TO_W(TO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (st != S_POLL),
        .en      (st == S_POLL),
        .limit   (cfg_poll_limit),
        .expired (tmr_exp)
    );
endmodule

// File: rtl/pio_sector_reader_chk.sv
module pio_sector_reader_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_detect,
    input logic [CNT_W-1:0] req_count,
    input logic [2:0]       ata_reg,
    input logic             ata_cs_cmd,
    input logic             ata_rd,
    input logic             ata_wr,
    input logic [15:0]      ata_wdata,
    input logic             out_valid,
    input logic             out_ready,
    input logic [15:0]      out_data,
    input logic             done,
    input logic [2:0]       done_code
);
    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ata_rd && ata_wr));

    assert_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_rd || ata_wr) |-> ata_cs_cmd);

    assert_hold_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_data_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !(ata_rd && ata_reg == 3'd0));

    assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_detect && req_count == '0)
        |=> (done && done_code == 3'd4));

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_cmd_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ata_wr && ata_reg == 3'd7) |-> (ata_wdata == 16'h0020 || ata_wdata == 16'h00EC));
endmodule

bind pio_sector_reader pio_sector_reader_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pio_sector_reader.sv
`timescale 1ns/1ps
module tb_pio_sector_reader;
    localparam int TO_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [TO_W-1:0] cfg_poll_limit = 16'd200;
    logic        req_valid = 0, req_detect = 0, req_chan = 0, req_drive = 0;
    logic [27:0] req_lba = '0;
    logic [7:0]  req_count = '0;
    logic        req_ready, ata_cs_cmd, ata_rd, ata_wr, out_valid, out_last, done;
    logic        out_ready = 0;
    logic [9:0]  io_port;
    logic [2:0]  ata_reg, done_code;
    logic [15:0] ata_wdata, ata_rdata, out_data;
    logic [7:0]  err_reg;

    pio_sector_reader dut (.*);

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dat_word(logic [27:0] lba, int s, int w);
        return ((lba[15:0] ^ {s[7:0], 8'h5A}) + {8'h00, w[7:0]}) ^ {lba[23:16], 8'h00};
    endfunction
    function automatic logic [15:0] id_word(int w);
        return 16'hC0DE ^ {w[7:0], w[7:0]};
    endfunction

    // Device model: 0 present, 1 absent, 2 error, 3 stuck busy
    int mode = 0, lat = 0;
    logic tb_chan = 0;
    int busy = 0, sec = 0, wrd = 0;
    logic drq = 0, errf = 0;
    logic [7:0] m_dev, m_cnt, m_lo, m_mid, m_hi, m_cmd;
    int wr_n = 0, stat_reads = 0, data_reads = 0, port_bad = 0;
    logic [2:0] wr_log [64];
    logic [7:0] wr_val [64];

    function automatic logic [7:0] m_status();
        if (mode == 1) return 8'h00;
        if (mode == 3) return 8'h80;
        if (busy > 0)  return 8'h80;
        if (errf)      return 8'h41;
        if (drq)       return 8'h58;
        return 8'h50;
    endfunction

    always_comb begin
        case (ata_reg)
            3'd0: ata_rdata = (m_cmd == 8'hEC) ? id_word(wrd)
                              : dat_word({4'h0, m_hi, m_mid, m_lo}, sec, wrd);
            3'd1: ata_rdata = 16'h0004;
            3'd7: ata_rdata = {8'h00, m_status()};
            default: ata_rdata = 16'h0000;
        endcase
    end

    always @(posedge clk) begin
        int nsec;
        nsec = (m_cmd == 8'hEC) ? 1 : int'(m_cnt);
        if ((ata_rd || ata_wr) && io_port != ((tb_chan ? 10'h170 : 10'h1F0) + {7'd0, ata_reg}))
            port_bad <= port_bad + 1;
        if (ata_wr) begin
            wr_log[wr_n % 64] <= ata_reg;
            wr_val[wr_n % 64] <= ata_wdata[7:0];
            wr_n <= wr_n + 1;
            case (ata_reg)
                3'd2: m_cnt <= ata_wdata[7:0];
                3'd3: m_lo  <= ata_wdata[7:0];
                3'd4: m_mid <= ata_wdata[7:0];
                3'd5: m_hi  <= ata_wdata[7:0];
                3'd6: m_dev <= ata_wdata[7:0];
                3'd7: begin
                    m_cmd <= ata_wdata[7:0];
                    sec <= 0; wrd <= 0; busy <= lat;
                    drq <= (mode == 0); errf <= (mode == 2);
                end
                default: ;
            endcase
        end else if (busy > 0) busy <= busy - 1;
        if (ata_rd && ata_reg == 3'd7) stat_reads <= stat_reads + 1;
        if (ata_rd && ata_reg == 3'd0) begin
            data_reads <= data_reads + 1;
            if (drq && busy == 0) begin
                if (wrd == 255) begin
                    wrd <= 0;
                    sec <= sec + 1;
                    if (sec + 1 >= nsec) drq <= 0;
                    else busy <= lat;
                end else wrd <= wrd + 1;
            end
        end
    end

    // Per-request results
    int got_n, bad_words, last_bad, stall_bad, cyc, wr_base, st_base;
    logic [2:0] got_code;

    task automatic run_req(input bit det, input bit ch, input bit drv, input logic [27:0] lba,
                           input logic [7:0] cnt, input int md, input int lt,
                           input int rdy_pct, input int stall);
        int exp_n, stall_left, k;
        logic [15:0] held;
        bit holding;
        mode = md; lat = lt; tb_chan = ch;
        exp_n = det ? 256 : 256 * int'(cnt);
        got_n = 0; bad_words = 0; last_bad = 0; stall_bad = 0; got_code = 3'd7;
        stall_left = stall; holding = 0; held = '0; k = 0;
        @(negedge clk);
        wr_base = wr_n; st_base = stat_reads;
        req_detect = det; req_chan = ch; req_drive = drv; req_lba = lba; req_count = cnt;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        cyc = 1;
        forever begin
            if (done) begin got_code = done_code; break; end
            if (out_valid && stall_left > 0) begin
                out_ready = 0;
                #1;
                if (holding && out_data != held) stall_bad++;
                if (ata_rd && ata_reg == 3'd0) stall_bad++;
                held = out_data; holding = 1;
                stall_left--;
            end else begin
                out_ready = (($urandom % 100) < rdy_pct);
                #1;
            end
            if (out_valid && out_ready) begin
                if (out_data != (det ? id_word(k % 256) : dat_word(lba, k / 256, k % 256)))
                    bad_words++;
                if (out_last != (k == exp_n - 1)) last_bad++;
                k++;
                got_n = k;
            end
            @(negedge clk);
            cyc++;
            if (cyc > 30000) begin
                chk(0, "watchdog", cyc, 30000);
                break;
            end
        end
        out_ready = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(out_valid == 1'b0 && done == 1'b0, "R1 reset outputs", {out_valid, done}, 0);
        chk(!ata_rd && !ata_wr, "R12 reset strobes", {ata_rd, ata_wr}, 0);
        rst_n = 1;
        @(negedge clk);

        // Constrained random reads
        for (int i = 0; i < 8; i++) begin
            bit ch, dv;
            logic [27:0] lba;
            logic [7:0] cnt;
            int lt;
            ch = 1'($urandom); dv = 1'($urandom);
            lba = 28'($urandom); cnt = 8'(1 + $urandom % 3); lt = $urandom % 16;
            run_req(0, ch, dv, lba, cnt, 0, lt, 70, 0);
            chk(got_code == 3'd0, "R1 read code ok", got_code, 0);
            chk(got_n == 256 * int'(cnt), "R6 word count", got_n, 256 * int'(cnt));
            chk(bad_words == 0, "R5 R6 word values", bad_words, 0);
            chk(last_bad == 0, "R6 last flag", last_bad, 0);
            chk(wr_n - wr_base == 6, "R2 write count", wr_n - wr_base, 6);
            chk(wr_log[(wr_base+0)%64] == 3'd6 && wr_log[(wr_base+1)%64] == 3'd2 &&
                wr_log[(wr_base+2)%64] == 3'd3 && wr_log[(wr_base+3)%64] == 3'd4 &&
                wr_log[(wr_base+4)%64] == 3'd5 && wr_log[(wr_base+5)%64] == 3'd7,
                "R2 write order", wr_log[(wr_base+1)%64], 2);
            chk(m_dev == {3'b111, dv, lba[27:24]}, "R2 device byte", m_dev, {3'b111, dv, lba[27:24]});
            chk({m_hi, m_mid, m_lo} == lba[23:0] && m_cnt == cnt, "R3 address bytes",
                {m_cnt, m_hi, m_mid, m_lo}, {cnt, lba[23:0]});
            chk(m_cmd == 8'h20, "R3 read command", m_cmd, 8'h20);
            chk(port_bad == 0, "R4 port address", port_bad, 0);
        end

        // Backpressure stall
        run_req(0, 1, 0, 28'h0ABCDEF, 8'd1, 0, 3, 100, 40);
        chk(stall_bad == 0, "R11 stall hold", stall_bad, 0);
        chk(got_n == 256 && bad_words == 0, "R11 words after stall", got_n, 256);

        // Detect, present device
        run_req(1, 0, 1, 28'h0000000, 8'd0, 0, 5, 80, 0);
        chk(got_code == 3'd0 && got_n == 256 && bad_words == 0, "R7 detect present",
            got_n, 256);
        chk(wr_n - wr_base == 2 && m_dev == 8'hB0 && m_cmd == 8'hEC, "R2 R3 detect writes",
            m_dev, 8'hB0);

        // Detect, absent device
        run_req(1, 1, 0, 28'h0, 8'd0, 1, 0, 80, 0);
        chk(got_code == 3'd1 && got_n == 0, "R7 detect absent", got_code, 1);
        chk(m_dev == 8'hA0, "R2 detect drive0 byte", m_dev, 8'hA0);

        // Detect with error status
        run_req(1, 0, 0, 28'h0, 8'd0, 2, 2, 80, 0);
        chk(got_code == 3'd1, "R7 detect error", got_code, 1);

        // Read with device error
        run_req(0, 0, 0, 28'h1234567, 8'd2, 2, 4, 80, 0);
        chk(got_code == 3'd2 && got_n == 0, "R8 error code", got_code, 2);
        chk(err_reg == 8'h04, "R8 error byte", err_reg, 8'h04);

        // Timeout on stuck busy
        cfg_poll_limit = 16'd30;
        run_req(0, 1, 1, 28'h0000100, 8'd1, 3, 0, 80, 0);
        chk(got_code == 3'd3, "R9 timeout code", got_code, 3);
        chk(stat_reads - st_base == 31, "R9 poll reads", stat_reads - st_base, 31);

        // Timeout on missing data request in read mode
        run_req(0, 0, 1, 28'h0000200, 8'd1, 1, 0, 80, 0);
        chk(got_code == 3'd3, "R9 no data request", got_code, 3);
        cfg_poll_limit = 16'd200;

        // Zero count
        run_req(0, 0, 0, 28'h0000300, 8'd0, 0, 0, 80, 0);
        chk(got_code == 3'd4, "R10 zero count code", got_code, 4);
        chk(cyc == 1, "R10 zero count timing", cyc, 1);
        chk(wr_n - wr_base == 0, "R10 no bus access", wr_n - wr_base, 0);
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R1 idle after done", {req_ready, done}, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule